// File: doc/BRIEF.md
# Host Window Decoder for a Network Controller Address PROM

This block sits between a host bus and a network controller. It splits each host access into one of two 16-byte windows. The lower window is a station-address PROM held inside the block. The upper window is handed to an external register port, which receives an address, a size code, write data and a request strobe. Any access that fits neither window is answered locally: a read returns all ones and a write has no effect.

One request channel carries both host front ends, and `host_req_space` picks between them. In I/O space the access width picks the window. Single bytes reach the PROM, and 16-bit or 32-bit accesses reach the register port. In memory space, address bit 4 picks the window. Wider PROM accesses there become byte operations at consecutive, wrapping offsets, and they are assembled little-endian.

PROM writes only take effect while the external write-enable input is high. The PROM is loaded from parameters at reset. Only one access is outstanding at a time: while a register-port access is in flight, the host channel is held off.

Top module: `nic_host_window`

## Requirements
- R1: After reset, `host_req_ready` is 1 and `host_rsp_valid` and `rp_req_valid` are 0. PROM byte n holds `STATION_ADDR[8n+7:8n]` for n = 0..5 and `PROM_TAIL[8(n-6)+7:8(n-6)]` for n = 6..15.
- R2: In I/O space (`host_req_space`=0), a byte access (size code 0) with address bit 4 clear targets PROM byte `addr[3:0]`. `host_rsp_valid` is 1 in the cycle after acceptance. Read data sits in bits [7:0] with the upper bits zero, and every write response carries zero data.
- R3: A PROM write changes storage only if `prom_wr_en` is 1 in the acceptance cycle. Otherwise the PROM keeps its contents, and the access is still answered as in R2.
- R4: In I/O space, a 16-bit (code 1) or 32-bit (code 2) access with address bit 4 set issues a register-port request. The request carries `rp_req_addr`=`addr[3:0]`, `rp_req_size` equal to the size code, the write flag and the write data. Read data returns masked to the access width.
- R5: Every other I/O-space combination, including size code 3, leaves the PROM unchanged and issues no register request. A read returns 0xFF, 0xFFFF or 0xFFFFFFFF by width (0xFFFFFFFF for code 3), one cycle after acceptance.
- R6: In memory space (`host_req_space`=1), address bit 4 clear selects the PROM for size codes 0 to 2. Bit 4 set with code 1 or 2 goes to the register port as in R4. Bit 4 set with a byte access reads 0xFF and ignores writes. Size code 3 reads 0xFFFFFFFF and ignores writes.
- R7: A memory-space 16-bit or 32-bit PROM write stores `wdata[7:0]` at the offset, `wdata[15:8]` at offset+1, and so on. Offsets wrap modulo 16, and every byte is gated by `prom_wr_en`.
- R8: A memory-space 16-bit or 32-bit PROM read returns the byte at the offset in bits [7:0], offset+1 in [15:8], and so on. Offsets wrap modulo 16.
- R9: `rp_req_valid` rises the cycle after a register access is accepted. Its fields stay stable until the cycle in which `rp_req_ready` is high. A write is answered on the host side the next cycle. A read waits for `rp_rsp_valid`, which counts only after the request was taken, and is answered the cycle after with the returned data.
- R10: `host_req_ready` is low from the cycle after a register access is accepted until the cycle its `host_rsp_valid` is high. `host_rsp_valid` is only ever high together with `host_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req_valid | input | 1 | Host access request |
| host_req_ready | output | 1 | Block can take a request |
| host_req_space | input | 1 | 0 = I/O space, 1 = memory space |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| host_req_addr | input | OFS_W+1 | Access offset; top bit selects window in memory space |
| host_req_wdata | input | DATA_W | Write data, little-endian lanes |
| prom_wr_en | input | 1 | External PROM write enable |
| host_rsp_valid | output | 1 | One-cycle response strobe |
| host_rsp_rdata | output | DATA_W | Read data (zero for writes) |
| rp_req_valid | output | 1 | Register-port request |
| rp_req_ready | input | 1 | Register port takes the request |
| rp_req_write | output | 1 | Register-port write flag |
| rp_req_addr | output | OFS_W | Register offset |
| rp_req_size | output | 2 | Register access size code |
| rp_req_wdata | output | DATA_W | Register write data |
| rp_rsp_valid | input | 1 | Register read data valid |
| rp_rsp_rdata | input | DATA_W | Register read data |

## Verification
The bound checker watches the register-port handshake on every cycle. It checks that request fields hold until they are taken, that only legal size codes appear, that the host channel stays closed while a request is in flight, and that write completions follow acceptance. It also checks the fixed answers: an all-ones byte read from the register window, and immediate completion of byte accesses to the PROM window.

PROM contents can only be seen through later reads, so only the bench scenarios can show the rest. That covers write gating, the split of wide writes, little-endian assembly with wrap-around, and the reset image. The same holds for masking of register read data and the exact stream of fields presented at the register port.

// File: rtl/nic_win_pkg.sv
package nic_win_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PROM = 2'd1,
    TGT_REG  = 2'd2
  } tgt_e;

  typedef enum logic [1:0] {
    RP_IDLE = 2'd0,
    RP_REQ  = 2'd1,
    RP_WAIT = 2'd2
  } rp_st_e;

endpackage

// File: rtl/nic_win_decode.sv
// Chooses the target window from space, size and address (R2, R4, R5, R6).
module nic_win_decode
  import nic_win_pkg::*;
#(
  parameter int OFS_W  = 4,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LCW   = $clog2(LANES) + 1
) (
  input  logic              space_mem,
  input  logic [1:0]        size,
  input  logic [OFS_W:0]    addr,
  output tgt_e              tgt,
  output logic [OFS_W-1:0]  ofs,
  output logic [LCW-1:0]    nbytes,
  output logic [DATA_W-1:0] width_mask
);

  logic      win_upper;
  acc_size_e sz;

  assign win_upper = addr[OFS_W];
  assign ofs       = addr[OFS_W-1:0];
  assign sz        = acc_size_e'(size);

  always_comb begin
    case (sz)
      SZ_BYTE: nbytes = LCW'(1);
      SZ_HALF: nbytes = LCW'(2);
      default: nbytes = LCW'(LANES);
    endcase
  end

  // Lane k of the all-ones fill / data mask is live when k < byte count.
  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign width_mask[8*g +: 8] = (LCW'(g) < nbytes) ? 8'hFF : 8'h00;
  end

  always_comb begin
    tgt = TGT_NONE;
    if (!space_mem) begin
      // I/O space: width picks the window
      if (sz == SZ_BYTE && !win_upper)
        tgt = TGT_PROM;
      else if ((sz == SZ_HALF || sz == SZ_WORD) && win_upper)
        tgt = TGT_REG;
    end else begin
      // memory space: address bit picks the window
      if (sz == SZ_RSVD)
        tgt = TGT_NONE;
      else if (!win_upper)
        tgt = TGT_PROM;
      else if (sz != SZ_BYTE)
        tgt = TGT_REG;
    end
  end

endmodule

// File: rtl/nic_win_prom.sv
// 16-byte station-address PROM with split, wrapping byte lanes (R1, R3, R7, R8).
module nic_win_prom #(
  parameter int OFS_W  = 4,
  parameter int DATA_W = 32,
  parameter logic [8*(1<<OFS_W)-1:0] INIT_IMAGE = '0,
  localparam int DEPTH = 1 << OFS_W,
  localparam int LANES = DATA_W / 8,
  localparam int LCW   = $clog2(LANES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic              wr_gate,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [LCW-1:0]    nbytes,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= INIT_IMAGE[8*i +: 8];
    end else if (wr_fire && wr_gate) begin
      for (int k = 0; k < LANES; k++)
        if (LCW'(k) < nbytes)
          mem[ofs + OFS_W'(k)] <= wdata[8*k +: 8];
    end
  end

  // Lane k reads the byte at offset + k, wrapping inside the window.
  for (genvar g = 0; g < LANES; g++) begin : g_rd
    logic [OFS_W-1:0] idx;
    assign idx = ofs + OFS_W'(g);
    assign rd_data[8*g +: 8] = mem[idx];
  end

endmodule

// File: rtl/nic_win_rport.sv
// Register-port request/response sequencer (R4, R9, R10).
module nic_win_rport
  import nic_win_pkg::*;
#(
  parameter int OFS_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_write,
  input  logic [OFS_W-1:0]  start_ofs,
  input  logic [1:0]        start_size,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic [DATA_W-1:0] start_mask,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] done_rdata,
  output logic              rp_req_valid,
  input  logic              rp_req_ready,
  output logic              rp_req_write,
  output logic [OFS_W-1:0]  rp_req_addr,
  output logic [1:0]        rp_req_size,
  output logic [DATA_W-1:0] rp_req_wdata,
  input  logic              rp_rsp_valid,
  input  logic [DATA_W-1:0] rp_rsp_rdata
);

  rp_st_e            st;
  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= RP_IDLE;
      rp_req_write <= 1'b0;
      rp_req_addr  <= '0;
      rp_req_size  <= 2'd0;
      rp_req_wdata <= '0;
      mask_q       <= '0;
    end else begin
      case (st)
        RP_IDLE: begin
          if (start) begin
            st           <= RP_REQ;
            rp_req_write <= start_write;
            rp_req_addr  <= start_ofs;
            rp_req_size  <= start_size;
            rp_req_wdata <= start_wdata;
            mask_q       <= start_mask;
          end
        end
        RP_REQ: begin
          if (rp_req_ready)
            st <= rp_req_write ? RP_IDLE : RP_WAIT;
        end
        RP_WAIT: begin
          if (rp_rsp_valid)
            st <= RP_IDLE;
        end
        default: st <= RP_IDLE;
      endcase
    end
  end

  assign busy         = (st != RP_IDLE);
  assign rp_req_valid = (st == RP_REQ);
  assign done         = (st == RP_REQ && rp_req_ready && rp_req_write) ||
                        (st == RP_WAIT && rp_rsp_valid);
  assign done_rdata   = rp_req_write ? '0 : (rp_rsp_rdata & mask_q);

endmodule

// File: rtl/nic_host_window.sv
// Host window decoder: PROM window plus register-port window (R1..R10).
module nic_host_window
  import nic_win_pkg::*;
#(
  parameter int OFS_W  = 4,
  parameter int DATA_W = 32,
  parameter logic [47:0] STATION_ADDR = 48'h665544332211,
  parameter logic [8*((1<<OFS_W)-6)-1:0] PROM_TAIL = 80'hF0E0D0C0B0A090807060,
  localparam int LANES = DATA_W / 8,
  localparam int LCW   = $clog2(LANES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_space,
  input  logic              host_req_write,
  input  logic [1:0]        host_req_size,
  input  logic [OFS_W:0]    host_req_addr,
  input  logic [DATA_W-1:0] host_req_wdata,
  input  logic              prom_wr_en,
  output logic              host_rsp_valid,
  output logic [DATA_W-1:0] host_rsp_rdata,
  output logic              rp_req_valid,
  input  logic              rp_req_ready,
  output logic              rp_req_write,
  output logic [OFS_W-1:0]  rp_req_addr,
  output logic [1:0]        rp_req_size,
  output logic [DATA_W-1:0] rp_req_wdata,
  input  logic              rp_rsp_valid,
  input  logic [DATA_W-1:0] rp_rsp_rdata
);

  localparam logic [8*(1<<OFS_W)-1:0] INIT_IMAGE = {PROM_TAIL, STATION_ADDR};

  tgt_e              tgt;
  logic [OFS_W-1:0]  ofs;
  logic [LCW-1:0]    nbytes;
  logic [DATA_W-1:0] width_mask;
  logic [DATA_W-1:0] prom_rd;
  logic              accept;
  logic              rp_busy;
  logic              rp_done;
  logic [DATA_W-1:0] rp_done_rdata;
  logic [DATA_W-1:0] local_rdata;

  nic_win_decode #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_dec (
    .space_mem  (host_req_space),
    .size       (host_req_size),
    .addr       (host_req_addr),
    .tgt        (tgt),
    .ofs        (ofs),
    .nbytes     (nbytes),
    .width_mask (width_mask)
  );

  assign host_req_ready = !rp_busy;
  assign accept         = host_req_valid && host_req_ready;

  nic_win_prom #(.OFS_W(OFS_W), .DATA_W(DATA_W), .INIT_IMAGE(INIT_IMAGE)) u_prom (
    .clk     (clk),
    .rst     (rst),
    .wr_fire (accept && host_req_write && tgt == TGT_PROM),
    .wr_gate (prom_wr_en),
    .ofs     (ofs),
    .nbytes  (nbytes),
    .wdata   (host_req_wdata),
    .rd_data (prom_rd)
  );

  nic_win_rport #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rport (
    .clk          (clk),
    .rst          (rst),
    .start        (accept && tgt == TGT_REG),
    .start_write  (host_req_write),
    .start_ofs    (ofs),
    .start_size   (host_req_size),
    .start_wdata  (host_req_wdata),
    .start_mask   (width_mask),
    .busy         (rp_busy),
    .done         (rp_done),
    .done_rdata   (rp_done_rdata),
    .rp_req_valid (rp_req_valid),
    .rp_req_ready (rp_req_ready),
    .rp_req_write (rp_req_write),
    .rp_req_addr  (rp_req_addr),
    .rp_req_size  (rp_req_size),
    .rp_req_wdata (rp_req_wdata),
    .rp_rsp_valid (rp_rsp_valid),
    .rp_rsp_rdata (rp_rsp_rdata)
  );

  // Locally answered accesses: PROM data, all-ones fill, or zero for writes.
  always_comb begin
    if (host_req_write)
      local_rdata = '0;
    else if (tgt == TGT_PROM)
      local_rdata = prom_rd & width_mask;
    else
      local_rdata = width_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rsp_valid <= 1'b0;
      host_rsp_rdata <= '0;
    end else begin
      host_rsp_valid <= (accept && tgt != TGT_REG) || rp_done;
      if (accept && tgt != TGT_REG)
        host_rsp_rdata <= local_rdata;
      else if (rp_done)
        host_rsp_rdata <= rp_done_rdata;
    end
  end

endmodule

// File: rtl/nic_host_window_chk.sv
module nic_host_window_chk #(
  parameter int OFS_W  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              host_req_valid,
  input logic              host_req_ready,
  input logic              host_req_space,
  input logic              host_req_write,
  input logic [1:0]        host_req_size,
  input logic [OFS_W:0]    host_req_addr,
  input logic              host_rsp_valid,
  input logic [DATA_W-1:0] host_rsp_rdata,
  input logic              rp_req_valid,
  input logic              rp_req_ready,
  input logic              rp_req_write,
  input logic [OFS_W-1:0]  rp_req_addr,
  input logic [1:0]        rp_req_size,
  input logic [DATA_W-1:0] rp_req_wdata
);

  logic acc;
  assign acc = host_req_valid && host_req_ready;

  assert_rp_hold_R9: assert property (@(posedge clk) disable iff (rst)
    rp_req_valid && !rp_req_ready |=> rp_req_valid && $stable(rp_req_addr) &&
      $stable(rp_req_size) && $stable(rp_req_wdata) && $stable(rp_req_write));

  assert_rp_wr_done_R9: assert property (@(posedge clk) disable iff (rst)
    rp_req_valid && rp_req_ready && rp_req_write |=> host_rsp_valid);

  assert_rp_size_R4: assert property (@(posedge clk) disable iff (rst)
    rp_req_valid |-> (rp_req_size == 2'd1 || rp_req_size == 2'd2));

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (rst)
    rp_req_valid |-> !host_req_ready);

  assert_rsp_when_ready_R10: assert property (@(posedge clk) disable iff (rst)
    host_rsp_valid |-> host_req_ready);

  assert_io_byte_fill_R5: assert property (@(posedge clk) disable iff (rst)
    acc && !host_req_space && !host_req_write && host_req_size == 2'd0 &&
      host_req_addr[OFS_W] |=> host_rsp_valid && host_rsp_rdata == DATA_W'(32'hFF));

  assert_mem_byte_fill_R6: assert property (@(posedge clk) disable iff (rst)
    acc && host_req_space && !host_req_write && host_req_size == 2'd0 &&
      host_req_addr[OFS_W] |=> host_rsp_valid && host_rsp_rdata == DATA_W'(32'hFF));

  assert_prom_byte_local_R2: assert property (@(posedge clk) disable iff (rst)
    acc && host_req_size == 2'd0 && !host_req_addr[OFS_W] |=> host_rsp_valid && !rp_req_valid);

endmodule

bind nic_host_window nic_host_window_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .host_req_valid (host_req_valid),
  .host_req_ready (host_req_ready),
  .host_req_space (host_req_space),
  .host_req_write (host_req_write),
  .host_req_size  (host_req_size),
  .host_req_addr  (host_req_addr),
  .host_rsp_valid (host_rsp_valid),
  .host_rsp_rdata (host_rsp_rdata),
  .rp_req_valid   (rp_req_valid),
  .rp_req_ready   (rp_req_ready),
  .rp_req_write   (rp_req_write),
  .rp_req_addr    (rp_req_addr),
  .rp_req_size    (rp_req_size),
  .rp_req_wdata   (rp_req_wdata)
);

// File: tb/tb_nic_host_window.sv
`timescale 1ns/1ps
module tb_nic_host_window;

  localparam logic [47:0] TB_STATION = 48'h0D1C2B3A4958;
  localparam logic [79:0] TB_TAIL    = 80'h13579BDF02468ACE1122;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic        host_req_space = 1'b0;
  logic        host_req_write = 1'b0;
  logic [1:0]  host_req_size = 2'd0;
  logic [4:0]  host_req_addr = 5'd0;
  logic [31:0] host_req_wdata = 32'd0;
  logic        prom_wr_en = 1'b0;
  logic        host_rsp_valid;
  logic [31:0] host_rsp_rdata;
  logic        rp_req_valid;
  logic        rp_req_ready = 1'b0;
  logic        rp_req_write;
  logic [3:0]  rp_req_addr;
  logic [1:0]  rp_req_size;
  logic [31:0] rp_req_wdata;
  logic        rp_rsp_valid = 1'b0;
  logic [31:0] rp_rsp_rdata = 32'd0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] model [16];

  always #4 clk = ~clk;

  nic_host_window #(.OFS_W(4), .DATA_W(32), .STATION_ADDR(TB_STATION), .PROM_TAIL(TB_TAIL)) dut (
    .clk(clk), .rst(rst),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_space(host_req_space), .host_req_write(host_req_write),
    .host_req_size(host_req_size), .host_req_addr(host_req_addr),
    .host_req_wdata(host_req_wdata), .prom_wr_en(prom_wr_en),
    .host_rsp_valid(host_rsp_valid), .host_rsp_rdata(host_rsp_rdata),
    .rp_req_valid(rp_req_valid), .rp_req_ready(rp_req_ready),
    .rp_req_write(rp_req_write), .rp_req_addr(rp_req_addr),
    .rp_req_size(rp_req_size), .rp_req_wdata(rp_req_wdata),
    .rp_rsp_valid(rp_rsp_valid), .rp_rsp_rdata(rp_rsp_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // 0 none, 1 PROM, 2 register port
  function automatic int exp_tgt(input bit sp, input logic [1:0] sz, input logic [4:0] ad);
    if (!sp) begin
      if (sz == 2'd0 && !ad[4]) return 1;
      if ((sz == 2'd1 || sz == 2'd2) && ad[4]) return 2;
      return 0;
    end
    if (sz == 2'd3) return 0;
    if (!ad[4]) return 1;
    if (sz != 2'd0) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] wmask(input logic [1:0] sz);
    case (sz)
      2'd0: return 32'h0000_00FF;
      2'd1: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int nbytes_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] prom_word(input logic [3:0] ofs);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = model[4'(ofs + 4'(k))];
    return w;
  endfunction

  function automatic logic [31:0] rp_data(input logic [3:0] a);
    return 32'h9E37_79B1 * (32'(a) + 32'd3);
  endfunction

  task automatic access(input bit sp, input bit wr, input logic [1:0] sz, input logic [4:0] ad,
                        input logic [31:0] wd, input bit en, input string tag,
                        output logic [31:0] rdata);
    int t;
    logic [31:0] exp;
    t = exp_tgt(sp, sz, ad);
    @(negedge clk);
    chk(host_req_ready === 1'b1, "R10", {31'd0, host_req_ready}, 32'd1);
    host_req_valid = 1'b1; host_req_space = sp; host_req_write = wr;
    host_req_size = sz; host_req_addr = ad; host_req_wdata = wd; prom_wr_en = en;
    @(negedge clk);
    host_req_valid = 1'b0; prom_wr_en = 1'b0;
    if (t == 2) begin
      chk(rp_req_valid === 1'b1 && rp_req_addr === ad[3:0] && rp_req_size === sz &&
          rp_req_write === wr && (!wr || rp_req_wdata === wd), tag,
          {rp_req_wdata[15:0], 8'(rp_req_addr), 6'd0, rp_req_size}, {wd[15:0], 8'(ad[3:0]), 6'd0, sz});
      chk(host_req_ready === 1'b0, "R10", {31'd0, host_req_ready}, 32'd0);
      for (int d = $urandom % 3; d > 0; d--) begin
        @(negedge clk);
        chk(rp_req_valid === 1'b1 && rp_req_addr === ad[3:0] && host_rsp_valid === 1'b0,
            "R9", {28'd0, rp_req_addr}, {28'd0, ad[3:0]});
      end
      rp_req_ready = 1'b1;
      @(negedge clk);
      rp_req_ready = 1'b0;
      if (wr) begin
        chk(host_rsp_valid === 1'b1 && host_rsp_rdata === 32'd0, "R9", host_rsp_rdata, 32'd0);
      end else begin
        chk(host_rsp_valid === 1'b0 && rp_req_valid === 1'b0, "R9",
            {31'd0, host_rsp_valid}, 32'd0);
        for (int d = $urandom % 3; d > 0; d--) begin
          @(negedge clk);
          chk(host_req_ready === 1'b0 && host_rsp_valid === 1'b0, "R10",
              {31'd0, host_req_ready}, 32'd0);
        end
        rp_rsp_valid = 1'b1; rp_rsp_rdata = rp_data(ad[3:0]);
        @(negedge clk);
        rp_rsp_valid = 1'b0; rp_rsp_rdata = 32'd0;
        exp = rp_data(ad[3:0]) & wmask(sz);
        chk(host_rsp_valid === 1'b1 && host_rsp_rdata === exp, tag, host_rsp_rdata, exp);
      end
    end else begin
      if (wr) exp = 32'd0;
      else if (t == 1) exp = prom_word(ad[3:0]) & wmask(sz);
      else exp = wmask(sz);
      chk(host_rsp_valid === 1'b1 && rp_req_valid === 1'b0 && host_rsp_rdata === exp,
          tag, host_rsp_rdata, exp);
      if (t == 1 && wr && en)
        for (int k = 0; k < nbytes_of(sz); k++) model[4'(ad[3:0] + 4'(k))] = wd[8*k +: 8];
    end
    rdata = host_rsp_rdata;
  endtask

  task automatic verify_prom(input string tag);
    logic [31:0] r;
    for (int i = 0; i < 16; i++) access(1'b0, 1'b0, 2'd0, 5'(i), 32'd0, 1'b0, tag, r);
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4242));
    for (int i = 0; i < 6; i++) model[i] = TB_STATION[8*i +: 8];
    for (int i = 6; i < 16; i++) model[i] = TB_TAIL[8*(i-6) +: 8];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(host_req_ready === 1'b1 && host_rsp_valid === 1'b0 && rp_req_valid === 1'b0, "R1",
        {29'd0, host_req_ready, host_rsp_valid, rp_req_valid}, 32'd4);
    verify_prom("R1");

    // R8: wrapping little-endian reads
    access(1'b1, 1'b0, 2'd2, 5'h0E, 32'd0, 1'b0, "R8", r);
    access(1'b1, 1'b0, 2'd1, 5'h0F, 32'd0, 1'b0, "R8", r);
    // R7: wrapping split writes, then observe bytes
    access(1'b1, 1'b1, 2'd2, 5'h0D, 32'hDEAD_BEEF, 1'b1, "R7", r);
    access(1'b1, 1'b1, 2'd1, 5'h07, 32'h0000_C3A5, 1'b1, "R7", r);
    verify_prom("R7");
    // R3: gated writes leave contents unchanged
    access(1'b0, 1'b1, 2'd0, 5'h03, 32'h0000_0077, 1'b0, "R3", r);
    access(1'b1, 1'b1, 2'd2, 5'h08, 32'h1234_5678, 1'b0, "R3", r);
    verify_prom("R3");
    // R5: invalid I/O combinations
    access(1'b0, 1'b0, 2'd0, 5'h12, 32'd0, 1'b0, "R5", r);
    access(1'b0, 1'b0, 2'd1, 5'h04, 32'd0, 1'b0, "R5", r);
    access(1'b0, 1'b0, 2'd2, 5'h08, 32'd0, 1'b0, "R5", r);
    access(1'b0, 1'b0, 2'd3, 5'h10, 32'd0, 1'b0, "R5", r);
    access(1'b0, 1'b1, 2'd1, 5'h02, 32'hAAAA_5555, 1'b1, "R5", r);
    access(1'b0, 1'b1, 2'd0, 5'h15, 32'h0000_00EE, 1'b1, "R5", r);
    verify_prom("R5");
    // R6: memory-space register window
    access(1'b1, 1'b0, 2'd0, 5'h13, 32'd0, 1'b0, "R6", r);
    access(1'b1, 1'b1, 2'd0, 5'h13, 32'h0000_0011, 1'b1, "R6", r);
    access(1'b1, 1'b0, 2'd3, 5'h01, 32'd0, 1'b0, "R6", r);
    access(1'b1, 1'b0, 2'd1, 5'h16, 32'd0, 1'b0, "R6", r);
    access(1'b1, 1'b1, 2'd2, 5'h1F, 32'hCAFE_F00D, 1'b0, "R6", r);
    // R4: I/O register port
    access(1'b0, 1'b1, 2'd2, 5'h1C, 32'h0BAD_CAFE, 1'b0, "R4", r);
    access(1'b0, 1'b0, 2'd1, 5'h1A, 32'd0, 1'b0, "R4", r);
    access(1'b0, 1'b0, 2'd2, 5'h10, 32'd0, 1'b0, "R4", r);
    // R2: byte PROM accesses in I/O space
    access(1'b0, 1'b1, 2'd0, 5'h05, 32'h0000_0042, 1'b1, "R2", r);
    access(1'b0, 1'b0, 2'd0, 5'h05, 32'd0, 1'b0, "R2", r);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [1:0] sz;
      logic [4:0] ad;
      bit sp;
      string tg;
      sp = 1'($urandom);
      sz = 2'($urandom);
      ad = 5'($urandom);
      case (exp_tgt(sp, sz, ad))
        1: tg = sp ? "R8" : "R2";
        2: tg = "R9";
        default: tg = sp ? "R6" : "R5";
      endcase
      access(sp, 1'($urandom), sz, ad, $urandom, 1'($urandom), tg, r);
    end
    verify_prom("R7");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule